// File: doc/BRIEF.md
# Hypervisor-Stage Access Gate and Memory-Type Merge

This block sits after the two address-translation stages of a core that runs guest operating systems under a hypervisor. For each access it receives the access kind, the memory type chosen by the guest-stage translation, and the permission bits and memory type chosen by the hypervisor-stage translation. It decides whether the access may go ahead or must be diverted to the hypervisor, and it produces the memory type that the rest of the memory system must use. The table walk that finds these fields is outside the block.

The final memory type is whichever of the two stage types is more restrictive. The hypervisor stage holds its own read, write and execute grants, and any of them may be withdrawn. A denied access raises a permission fault that goes to the hypervisor. Setting one configuration input also makes every guest access that ends up as device memory trap to the hypervisor, so that it can stand in for the hardware. When the virtualization input is low, the guest stage acts alone.

The result is registered and appears one cycle after a valid request.

Top module: `hyp_access_gate`

## Requirements
- R1: A request with `in_valid` high produces `out_valid` high on the next clock edge, with that request's result on the outputs. A cycle with `in_valid` low gives `out_valid` low on the next edge and leaves `out_mtype`, `out_pass`, `out_trap` and `out_reason` unchanged.
- R2: Memory type codes are 00 device, 01 normal non-cacheable and 10 normal cacheable. An input code of 11 counts as 10. With virtualization on, `out_mtype` is the numerically smaller of the two normalized stage codes.
- R3: A guest-stage device type (00) combined with a hypervisor-stage normal cacheable type (10) gives device (00).
- R4: `h_perm` bit 0 grants read, bit 1 grants write and bit 2 grants execute. The `acc_kind` values are 00 read, 01 write and 10 execute, and 11 is treated as read. With virtualization on, a cleared grant bit for the access kind gives `out_trap`=1 and `out_reason`=01.
- R5: With virtualization on, `dev_trap_en`=1, the access permitted and a merged type of device, the result is `out_trap`=1 and `out_reason`=10.
- R6: When a permission fault and a device trap both apply, `out_reason` is 01.
- R7: With `virt_en`=0, `out_mtype` is the normalized guest code, `out_pass`=1 and `out_reason`=00, whatever the hypervisor-stage inputs and `dev_trap_en` are.
- R8: While `out_valid` is high, exactly one of `out_pass` and `out_trap` is high, and `out_reason` is 00 exactly when `out_pass` is high.
- R9: After reset, `out_valid`, `out_pass` and `out_trap` are 0, and `out_reason` and `out_mtype` are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| virt_en | input | 1 | Hypervisor stage active |
| dev_trap_en | input | 1 | Trap guest accesses that resolve to device memory |
| acc_kind | input | 2 | 00 read, 01 write, 10 execute, 11 read |
| g_mtype | input | 2 | Guest-stage memory type code |
| h_mtype | input | 2 | Hypervisor-stage memory type code |
| h_perm | input | 3 | Hypervisor-stage grants: bit0 read, bit1 write, bit2 execute |
| out_valid | output | 1 | Result present |
| out_mtype | output | 2 | Merged memory type code |
| out_pass | output | 1 | Access may proceed |
| out_trap | output | 1 | Access is diverted to the hypervisor |
| out_reason | output | 2 | 00 none, 01 permission fault, 10 device trap |

## Verification
The hardest case to reach is a request where a withdrawn grant and a device trap apply together. It needs virtualization on, the device trap enabled, a device type from at least one stage, and the grant for that exact access kind cleared. The bench sweeps every combination of the configuration inputs, access kinds, both stage codes (including the spare 11 code) and all eight grant patterns, back to back, so every such overlap occurs. A directed idle cycle with changed inputs then shows that the outputs hold.

// File: rtl/hag_pkg.sv
package hag_pkg;
  localparam int MT_W   = 2;
  localparam int RSN_W  = 2;
  localparam int KIND_W = 2;
  localparam int NPERM  = 3;

  localparam logic [MT_W-1:0] MT_DEV   = 2'b00;
  localparam logic [MT_W-1:0] MT_NC    = 2'b01;
  localparam logic [MT_W-1:0] MT_CACHE = 2'b10;

  localparam logic [RSN_W-1:0] RSN_NONE = 2'b00;
  localparam logic [RSN_W-1:0] RSN_PERM = 2'b01;
  localparam logic [RSN_W-1:0] RSN_DEV  = 2'b10;

  localparam logic [KIND_W-1:0] ACC_RD = 2'b00;
  localparam logic [KIND_W-1:0] ACC_WR = 2'b01;
  localparam logic [KIND_W-1:0] ACC_EX = 2'b10;

  // Spare code 11 folds onto normal cacheable
  function automatic logic [MT_W-1:0] mt_norm(input logic [MT_W-1:0] c);
    return (c > MT_CACHE) ? MT_CACHE : c;
  endfunction

  // Smaller code is more restrictive
  function automatic logic [MT_W-1:0] mt_stricter(input logic [MT_W-1:0] a,
                                                  input logic [MT_W-1:0] b);
    logic [MT_W-1:0] na, nb;
    na = mt_norm(a);
    nb = mt_norm(b);
    return (na < nb) ? na : nb;
  endfunction

  // Which grant bit governs an access kind
  function automatic int unsigned grant_bit(input logic [KIND_W-1:0] k);
    case (k)
      ACC_WR:  return 1;
      ACC_EX:  return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/hag_type_merge.sv
module hag_type_merge
  import hag_pkg::*;
(
  input  logic            virt_en,
  input  logic [MT_W-1:0] g_code,
  input  logic [MT_W-1:0] h_code,
  output logic [MT_W-1:0] merged
);
  always_comb begin
    if (virt_en) merged = mt_stricter(g_code, h_code);
    else         merged = mt_norm(g_code);
  end
endmodule

// File: rtl/hag_perm_check.sv
module hag_perm_check
  import hag_pkg::*;
#(
  parameter int N = NPERM
) (
  input  logic              virt_en,
  input  logic [KIND_W-1:0] acc_kind,
  input  logic [N-1:0]      grants,
  output logic              deny
);
  logic [N-1:0] sel;
  logic [N-1:0] miss;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign sel[i]  = (grant_bit(acc_kind) == i);
    assign miss[i] = sel[i] & ~grants[i];
  end

  assign deny = virt_en & (|miss);
endmodule

// File: rtl/hag_trap_arbiter.sv
module hag_trap_arbiter
  import hag_pkg::*;
(
  input  logic             virt_en,
  input  logic             dev_trap_en,
  input  logic             deny,
  input  logic [MT_W-1:0]  merged,
  output logic             dev_hit,
  output logic [RSN_W-1:0] reason
);
  assign dev_hit = virt_en & dev_trap_en & (merged == MT_DEV);

  // Permission fault outranks device trap
  always_comb begin
    if (deny)         reason = RSN_PERM;
    else if (dev_hit) reason = RSN_DEV;
    else              reason = RSN_NONE;
  end
endmodule

// File: rtl/hyp_access_gate.sv
module hyp_access_gate
  import hag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              virt_en,
  input  logic              dev_trap_en,
  input  logic [KIND_W-1:0] acc_kind,
  input  logic [MT_W-1:0]   g_mtype,
  input  logic [MT_W-1:0]   h_mtype,
  input  logic [NPERM-1:0]  h_perm,
  output logic              out_valid,
  output logic [MT_W-1:0]   out_mtype,
  output logic              out_pass,
  output logic              out_trap,
  output logic [RSN_W-1:0]  out_reason
);
  // Named internal events, observed by the checker
  logic [MT_W-1:0]  merged_w;
  logic             perm_deny_w;
  logic             dev_hit_w;
  logic [RSN_W-1:0] reason_w;

  hag_type_merge u_merge (
    .virt_en (virt_en),
    .g_code  (g_mtype),
    .h_code  (h_mtype),
    .merged  (merged_w)
  );

  hag_perm_check #(.N(NPERM)) u_perm (
    .virt_en  (virt_en),
    .acc_kind (acc_kind),
    .grants   (h_perm),
    .deny     (perm_deny_w)
  );

  hag_trap_arbiter u_arb (
    .virt_en     (virt_en),
    .dev_trap_en (dev_trap_en),
    .deny        (perm_deny_w),
    .merged      (merged_w),
    .dev_hit     (dev_hit_w),
    .reason      (reason_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_mtype  <= MT_DEV;
      out_pass   <= 1'b0;
      out_trap   <= 1'b0;
      out_reason <= RSN_NONE;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mtype  <= merged_w;
        out_reason <= reason_w;
        out_trap   <= (reason_w != RSN_NONE);
        out_pass   <= (reason_w == RSN_NONE);
      end
    end
  end
endmodule

// File: rtl/hag_checker.sv
module hag_checker
  import hag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              virt_en,
  input logic [MT_W-1:0]   g_mtype,
  input logic              perm_deny_w,
  input logic              dev_hit_w,
  input logic              out_valid,
  input logic [MT_W-1:0]   out_mtype,
  input logic              out_pass,
  input logic              out_trap,
  input logic [RSN_W-1:0]  out_reason
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_mtype) && $stable(out_reason)
                   && $stable(out_pass)));

  p_merge_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_mtype <= mt_norm($past(g_mtype))));

  p_perm_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && perm_deny_w) |=> (out_trap && out_reason == RSN_PERM));

  p_dev_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dev_hit_w && !perm_deny_w) |=> (out_reason == RSN_DEV));

  p_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dev_hit_w && perm_deny_w) |=> (out_reason == RSN_PERM));

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !virt_en) |=> (out_pass && out_reason == RSN_NONE
                                && out_mtype == mt_norm($past(g_mtype))));

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_pass != out_trap) && (out_pass == (out_reason == RSN_NONE))));
endmodule

bind hyp_access_gate hag_checker u_hag_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .virt_en     (virt_en),
  .g_mtype     (g_mtype),
  .perm_deny_w (perm_deny_w),
  .dev_hit_w   (dev_hit_w),
  .out_valid   (out_valid),
  .out_mtype   (out_mtype),
  .out_pass    (out_pass),
  .out_trap    (out_trap),
  .out_reason  (out_reason)
);

// File: tb/tb_hyp_access_gate.sv
module tb_hyp_access_gate;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, virt_en, dev_trap_en;
  logic [1:0] acc_kind, g_mtype, h_mtype;
  logic [2:0] h_perm;
  logic       out_valid, out_pass, out_trap;
  logic [1:0] out_mtype, out_reason;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hyp_access_gate dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .virt_en(virt_en),
    .dev_trap_en(dev_trap_en), .acc_kind(acc_kind), .g_mtype(g_mtype),
    .h_mtype(h_mtype), .h_perm(h_perm), .out_valid(out_valid),
    .out_mtype(out_mtype), .out_pass(out_pass), .out_trap(out_trap),
    .out_reason(out_reason)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int gn, hn, m, bitn, rsn;
    bit deny, dev;
    string tm, tr;
    rst_n = 1'b0; in_valid = 1'b0; virt_en = 1'b0; dev_trap_en = 1'b0;
    acc_kind = 2'd0; g_mtype = 2'd0; h_mtype = 2'd0; h_perm = 3'd0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "out_valid",  out_valid,  0);
    check("R9", "out_pass",   out_pass,   0);
    check("R9", "out_trap",   out_trap,   0);
    check("R9", "out_reason", out_reason, 0);
    check("R9", "out_mtype",  out_mtype,  0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle out_valid", out_valid, 0);

    for (int v = 0; v < 2; v++)
      for (int d = 0; d < 2; d++)
        for (int k = 0; k < 4; k++)
          for (int g = 0; g < 4; g++)
            for (int h = 0; h < 4; h++)
              for (int p = 0; p < 8; p++) begin
                in_valid = 1'b1; virt_en = v[0]; dev_trap_en = d[0];
                acc_kind = k[1:0]; g_mtype = g[1:0]; h_mtype = h[1:0]; h_perm = p[2:0];
                gn = (g == 3) ? 2 : g;
                hn = (h == 3) ? 2 : h;
                m = (v == 1) ? ((gn < hn) ? gn : hn) : gn;
                bitn = (k == 1) ? 1 : ((k == 2) ? 2 : 0);
                deny = (v == 1) && (((p >> bitn) & 1) == 0);
                dev  = (v == 1) && (d == 1) && (m == 0);
                rsn  = deny ? 1 : (dev ? 2 : 0);
                if (v == 0)                      tm = "R7";
                else if (gn == 0 && hn == 2)     tm = "R3";
                else                             tm = "R2";
                if (v == 0)           tr = "R7";
                else if (deny && dev) tr = "R6";
                else if (dev)         tr = "R5";
                else                  tr = "R4";
                @(negedge clk);
                check("R1", "out_valid", out_valid, 1);
                check(tm, "out_mtype", out_mtype, m);
                check(tr, "out_reason", out_reason, rsn);
                check("R8", "out_trap", out_trap, (rsn != 0) ? 1 : 0);
                check("R8", "out_pass", out_pass, (rsn == 0) ? 1 : 0);
              end

    // R1: known result, then an idle cycle with changed inputs must hold it
    in_valid = 1'b1; virt_en = 1'b1; dev_trap_en = 1'b1; acc_kind = 2'd0;
    g_mtype = 2'd0; h_mtype = 2'd2; h_perm = 3'b111;
    @(negedge clk);
    check("R5", "out_reason", out_reason, 2);
    in_valid = 1'b0; virt_en = 1'b0; g_mtype = 2'd2; h_perm = 3'b000;
    @(negedge clk);
    check("R1", "hold out_valid",  out_valid,  0);
    check("R1", "hold out_mtype",  out_mtype,  0);
    check("R1", "hold out_reason", out_reason, 2);
    check("R1", "hold out_pass",   out_pass,   0);
    check("R1", "hold out_trap",   out_trap,   1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule